// File: doc/BRIEF.md
# Raster Timing Generator with Pixel-Precise Vertical Edges

This block produces the timing strobes for a progressive video raster from a pixel clock. A horizontal pixel counter and a vertical line counter step through the frame, and registered decodes of the counter position drive active video, horizontal blanking, horizontal sync, vertical blanking and vertical sync. All sizes and positions come from static configuration inputs. They are meant to change only while the block is held in reset.

Vertical blanking and vertical sync are not limited to line boundaries. Each of their four edges is set by a line number and a pixel position within that line, so it can fall on any pixel clock. For a 1280x720 raster with 1650 clocks per line and 750 lines, vertical blanking set at line 719, pixel 1280 and cleared at line 0, pixel 0 tracks active video exactly. Moving the set pixel to 1285 makes blanking start five clocks after the last active pixel. A clear at line 749, pixel 1645 ends blanking five clocks before the first active pixel of the next frame. In the 720p setup, horizontal sync covers pixels 1390 to 1429, so its configured end is 1430.

Top module: `raster_timer`

## Requirements
- R1: While rst_ni is low all five outputs are low. After release, the first enabled clock edge presents position (h=0, v=0).
- R2: Each enabled edge advances h by one. h wraps from h_total-1 to 0 and then advances v, and v wraps from v_total-1 to 0, so the pattern repeats every h_total*v_total enabled clocks.
- R3: active_o is high exactly when h < h_active and v < v_active.
- R4: hblank_o is high exactly when h >= h_active. hsync_o is high exactly when hs_start <= h < hs_end, with the end exclusive.
- R5: vblank_o goes high at position (vb_start_line, vb_start_pix), goes low at position (vb_end_line, vb_end_pix), and otherwise keeps its value.
- R6: vsync_o goes high at position (vs_start_line, vs_start_pix), goes low at position (vs_end_line, vs_end_pix), and otherwise keeps its value.
- R7: When vertical blanking is set at (v_active-1, h_active) and cleared at (0, 0), vblank_o rises on the same edge on which active_o falls and falls on the same edge on which active_o rises.
- R8: When the set position and the clear position of a vertical signal coincide, the clear wins and the signal stays low.
- R9: While ce_i is low the counters and all outputs hold their values, and the raster resumes from the held position.
- R10: Every output is registered and shows the decode of a position one clock edge after the counters hold that position. All five outputs share that latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Clock enable |
| h_active_i | input | HW | Active pixels per line |
| h_total_i | input | HW | Clocks per line |
| hs_start_i | input | HW | First pixel of horizontal sync |
| hs_end_i | input | HW | Pixel after the last pixel of horizontal sync |
| v_active_i | input | VW | Active lines per frame |
| v_total_i | input | VW | Lines per frame |
| vb_start_line_i | input | VW | Line on which vertical blanking is set |
| vb_start_pix_i | input | HW | Pixel on which vertical blanking is set |
| vb_end_line_i | input | VW | Line on which vertical blanking is cleared |
| vb_end_pix_i | input | HW | Pixel on which vertical blanking is cleared |
| vs_start_line_i | input | VW | Line on which vertical sync is set |
| vs_start_pix_i | input | HW | Pixel on which vertical sync is set |
| vs_end_line_i | input | VW | Line on which vertical sync is cleared |
| vs_end_pix_i | input | HW | Pixel on which vertical sync is cleared |
| active_o | output | 1 | Active video |
| hblank_o | output | 1 | Horizontal blanking |
| hsync_o | output | 1 | Horizontal sync |
| vblank_o | output | 1 | Vertical blanking |
| vsync_o | output | 1 | Vertical sync |

## Verification
A wrong horizontal count shows up within one line as hblank_o or hsync_o edges at the wrong positions. A wrong line count shows up at the next frame boundary as active_o misplaced against vblank_o. Because the vertical flags hold state between their edges, a missed or extra set or clear leaves vblank_o or vsync_o wrong for up to a whole frame. The bench therefore samples them just before and just after each programmed edge and again after the frame wraps. A lost enable shows as a position that fails to advance, which the first edge after ce_i returns exposes.

// File: rtl/rt_pkg.sv
package rt_pkg;
  localparam int unsigned HW_DEF   = 12;
  localparam int unsigned VW_DEF   = 12;
  localparam int unsigned NUM_VSIG = 2;
  localparam int unsigned VSIG_BLANK = 0;
  localparam int unsigned VSIG_SYNC  = 1;
endpackage

// File: rtl/rt_counter.sv
module rt_counter #(
  parameter int unsigned HW = rt_pkg::HW_DEF,
  parameter int unsigned VW = rt_pkg::VW_DEF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_i,
  input  logic [HW-1:0] h_total_i,
  input  logic [VW-1:0] v_total_i,
  output logic [HW-1:0] h_o,
  output logic [VW-1:0] v_o
);
  localparam logic [HW-1:0] H_ONE = HW'(1);
  localparam logic [VW-1:0] V_ONE = VW'(1);

  logic [HW-1:0] h_q;
  logic [VW-1:0] v_q;
  logic          h_last, v_last;

  // >= guards against a counter stranded above a shrunken total
  assign h_last = (h_q >= h_total_i - H_ONE);
  assign v_last = (v_q >= v_total_i - V_ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
      v_q <= '0;
    end else if (ce_i) begin
      if (h_last) begin
        h_q <= '0;
        v_q <= v_last ? '0 : v_q + V_ONE;
      end else begin
        h_q <= h_q + H_ONE;
      end
    end
  end

  assign h_o = h_q;
  assign v_o = v_q;

  a_r2_h_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_q < h_total_i);
  a_r2_h_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && h_q == h_total_i - H_ONE) |=> (h_q == '0));
  a_r9_count_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> ($stable(h_q) && $stable(v_q)));
endmodule

// File: rtl/rt_hdecode.sv
module rt_hdecode #(
  parameter int unsigned HW = rt_pkg::HW_DEF,
  parameter int unsigned VW = rt_pkg::VW_DEF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_i,
  input  logic [HW-1:0] h_i,
  input  logic [VW-1:0] v_i,
  input  logic [HW-1:0] h_active_i,
  input  logic [HW-1:0] hs_start_i,
  input  logic [HW-1:0] hs_end_i,
  input  logic [VW-1:0] v_active_i,
  output logic          active_o,
  output logic          hblank_o,
  output logic          hsync_o
);
  logic act_d, hb_d, hs_d;
  logic act_q, hb_q, hs_q;

  always_comb begin
    hb_d  = (h_i >= h_active_i);
    act_d = !hb_d && (v_i < v_active_i);
    hs_d  = (h_i >= hs_start_i) && (h_i < hs_end_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      hb_q  <= 1'b0;
      hs_q  <= 1'b0;
    end else if (ce_i) begin
      act_q <= act_d;
      hb_q  <= hb_d;
      hs_q  <= hs_d;
    end
  end

  assign active_o = act_q;
  assign hblank_o = hb_q;
  assign hsync_o  = hs_q;

  a_r4_active_not_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(act_q && hb_q));
  a_r9_hdec_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> ($stable(act_q) && $stable(hb_q) && $stable(hs_q)));
  a_r10_hb_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && h_i == '0) |=> !hb_q);
endmodule

// File: rtl/rt_vedge.sv
module rt_vedge #(
  parameter int unsigned HW = rt_pkg::HW_DEF,
  parameter int unsigned VW = rt_pkg::VW_DEF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_i,
  input  logic [HW-1:0] h_i,
  input  logic [VW-1:0] v_i,
  input  logic [VW-1:0] set_line_i,
  input  logic [HW-1:0] set_pix_i,
  input  logic [VW-1:0] clr_line_i,
  input  logic [HW-1:0] clr_pix_i,
  output logic          flag_o
);
  logic set_hit, clr_hit, flag_q;

  assign set_hit = (v_i == set_line_i) && (h_i == set_pix_i);
  assign clr_hit = (v_i == clr_line_i) && (h_i == clr_pix_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          flag_q <= 1'b0;
    else if (ce_i) begin
      if (clr_hit)        flag_q <= 1'b0;   // clear has priority
      else if (set_hit)   flag_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;

  a_r5_flag_rise_at_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(ce_i && v_i == set_line_i && h_i == set_pix_i));
  a_r6_flag_fall_at_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> $past(ce_i && v_i == clr_line_i && h_i == clr_pix_i));
  a_r8_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && v_i == clr_line_i && h_i == clr_pix_i) |=> !flag_q);
endmodule

// File: rtl/raster_timer.sv
module raster_timer #(
  parameter int unsigned HW = rt_pkg::HW_DEF,
  parameter int unsigned VW = rt_pkg::VW_DEF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_i,
  input  logic [HW-1:0] h_active_i,
  input  logic [HW-1:0] h_total_i,
  input  logic [HW-1:0] hs_start_i,
  input  logic [HW-1:0] hs_end_i,
  input  logic [VW-1:0] v_active_i,
  input  logic [VW-1:0] v_total_i,
  input  logic [VW-1:0] vb_start_line_i,
  input  logic [HW-1:0] vb_start_pix_i,
  input  logic [VW-1:0] vb_end_line_i,
  input  logic [HW-1:0] vb_end_pix_i,
  input  logic [VW-1:0] vs_start_line_i,
  input  logic [HW-1:0] vs_start_pix_i,
  input  logic [VW-1:0] vs_end_line_i,
  input  logic [HW-1:0] vs_end_pix_i,
  output logic          active_o,
  output logic          hblank_o,
  output logic          hsync_o,
  output logic          vblank_o,
  output logic          vsync_o
);
  import rt_pkg::*;

  logic [HW-1:0] h_pos;
  logic [VW-1:0] v_pos;

  logic [VW-1:0] set_line [NUM_VSIG];
  logic [HW-1:0] set_pix  [NUM_VSIG];
  logic [VW-1:0] clr_line [NUM_VSIG];
  logic [HW-1:0] clr_pix  [NUM_VSIG];
  logic [NUM_VSIG-1:0] vflag;

  assign set_line[VSIG_BLANK] = vb_start_line_i;
  assign set_pix [VSIG_BLANK] = vb_start_pix_i;
  assign clr_line[VSIG_BLANK] = vb_end_line_i;
  assign clr_pix [VSIG_BLANK] = vb_end_pix_i;
  assign set_line[VSIG_SYNC]  = vs_start_line_i;
  assign set_pix [VSIG_SYNC]  = vs_start_pix_i;
  assign clr_line[VSIG_SYNC]  = vs_end_line_i;
  assign clr_pix [VSIG_SYNC]  = vs_end_pix_i;

  rt_counter #(.HW(HW), .VW(VW)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ce_i      (ce_i),
    .h_total_i (h_total_i),
    .v_total_i (v_total_i),
    .h_o       (h_pos),
    .v_o       (v_pos)
  );

  rt_hdecode #(.HW(HW), .VW(VW)) u_hdec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ce_i       (ce_i),
    .h_i        (h_pos),
    .v_i        (v_pos),
    .h_active_i (h_active_i),
    .hs_start_i (hs_start_i),
    .hs_end_i   (hs_end_i),
    .v_active_i (v_active_i),
    .active_o   (active_o),
    .hblank_o   (hblank_o),
    .hsync_o    (hsync_o)
  );

  for (genvar g = 0; g < NUM_VSIG; g++) begin : g_vsig
    rt_vedge #(.HW(HW), .VW(VW)) u_ve (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ce_i       (ce_i),
      .h_i        (h_pos),
      .v_i        (v_pos),
      .set_line_i (set_line[g]),
      .set_pix_i  (set_pix[g]),
      .clr_line_i (clr_line[g]),
      .clr_pix_i  (clr_pix[g]),
      .flag_o     (vflag[g])
    );
  end

  assign vblank_o = vflag[VSIG_BLANK];
  assign vsync_o  = vflag[VSIG_SYNC];

  a_r9_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> ($stable(vblank_o) && $stable(vsync_o) && $stable(active_o)));
  a_r3_active_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && v_pos >= v_active_i) |=> !active_o);
endmodule

// File: tb/raster_timer_test.sv
module raster_timer_test;
  localparam int unsigned HW = 12;
  localparam int unsigned VW = 12;
  localparam int NV = 16;
  // position p = v*20 + h; expected {active, hblank, hsync, vblank, vsync}
  localparam int unsigned VEC_P [NV] = '{0, 11, 12, 14, 16, 17, 19, 111,
                                         112, 120, 139, 140, 174, 175, 199, 200};
  localparam logic [4:0]  VEC_E [NV] = '{5'b10000, 5'b10000, 5'b01000, 5'b01100,
                                         5'b01100, 5'b01000, 5'b01000, 5'b10000,
                                         5'b01010, 5'b00010, 5'b01010, 5'b00011,
                                         5'b01111, 5'b01110, 5'b01010, 5'b10000};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ce_i = 1'b1;
  logic [HW-1:0] h_active, h_total, hs_start, hs_end;
  logic [VW-1:0] v_active, v_total;
  logic [VW-1:0] vbs_l, vbe_l, vss_l, vse_l;
  logic [HW-1:0] vbs_p, vbe_p, vss_p, vse_p;
  logic active_o, hblank_o, hsync_o, vblank_o, vsync_o;
  int checks = 0;
  int errors = 0;
  int edges = 0;

  always #4 clk = ~clk;

  raster_timer #(.HW(HW), .VW(VW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .ce_i(ce_i),
    .h_active_i(h_active), .h_total_i(h_total), .hs_start_i(hs_start), .hs_end_i(hs_end),
    .v_active_i(v_active), .v_total_i(v_total),
    .vb_start_line_i(vbs_l), .vb_start_pix_i(vbs_p), .vb_end_line_i(vbe_l), .vb_end_pix_i(vbe_p),
    .vs_start_line_i(vss_l), .vs_start_pix_i(vss_p), .vs_end_line_i(vse_l), .vs_end_pix_i(vse_p),
    .active_o(active_o), .hblank_o(hblank_o), .hsync_o(hsync_o),
    .vblank_o(vblank_o), .vsync_o(vsync_o)
  );

  function automatic logic [4:0] outs();
    return {active_o, hblank_o, hsync_o, vblank_o, vsync_o};
  endfunction

  task automatic chk(input string tag, input logic [4:0] exp);
    checks++;
    if (outs() !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, outs(), exp);
    end
  endtask

  task automatic base_cfg();
    h_active = 12; h_total = 20; hs_start = 14; hs_end = 17;
    v_active = 6;  v_total = 10;
    vbs_l = 5; vbs_p = 12; vbe_l = 0; vbe_p = 0;
    vss_l = 7; vss_p = 0;  vse_l = 8; vse_p = 15;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    ce_i = 1'b1;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    edges = 0;
  endtask

  // run until the outputs show position p
  task automatic go_to(input int p);
    repeat (p + 1 - edges) @(posedge clk);
    edges = p + 1;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    base_cfg();
    #1;
    chk("R1 reset low", 5'b00000);
    do_reset();
    chk("R1 after release before edge", 5'b00000);

    // R2 R3 R4 R5 R6 R7 R10: table walk over one frame and the wrap
    for (int i = 0; i < NV; i++) begin
      go_to(int'(VEC_P[i]));
      chk($sformatf("R2 R3 R4 R5 R6 R7 R10 vec %0d pos %0d", i, VEC_P[i]), VEC_E[i]);
    end

    // R1: asynchronous reset mid-frame, restart at (0,0)
    go_to(230);
    rst_ni = 1'b0;
    #1;
    chk("R1 async reset", 5'b00000);
    @(negedge clk);
    rst_ni = 1'b1;
    edges = 0;
    go_to(0);
    chk("R1 first position", 5'b10000);

    // R9: enable held low
    go_to(12);
    chk("R9 before hold", 5'b01000);
    ce_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 held", 5'b01000);
    ce_i = 1'b1;
    go_to(13);
    chk("R9 resume h13", 5'b01000);
    go_to(14);
    chk("R9 resume h14", 5'b01100);

    // R5: fine-shifted vertical blanking edges
    base_cfg();
    vbs_p = 17; vbe_l = 9; vbe_p = 15;
    do_reset();
    go_to(112);
    chk("R5 no rise at line boundary", 5'b01000);
    go_to(116);
    chk("R5 before fine set", 5'b01100);
    go_to(117);
    chk("R5 fine set", 5'b01010);
    go_to(194);
    chk("R5 before fine clear", 5'b01110);
    go_to(195);
    chk("R5 fine clear", 5'b01100);
    go_to(200);
    chk("R5 next frame", 5'b10000);

    // R8: coincident set and clear keep vsync low
    base_cfg();
    vse_l = 7; vse_p = 0;
    do_reset();
    go_to(140);
    chk("R8 coincide at edge", 5'b00010);
    go_to(160);
    chk("R8 later line", 5'b00010);
    go_to(199);
    chk("R8 frame end", 5'b01010);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule